// File: doc/BRIEF.md
# Operand Barrel Shifter

This block prepares the second operand of an integer ALU in a single combinational pass. A 32-bit source value is shifted or rotated according to a 2-bit operation code and an amount. It also produces a shifter carry-out that the flag logic downstream may capture. The amount comes either from a 5-bit instruction field or from the low byte of a register. A zero in the instruction field has special meanings for some operation codes, and register amounts of 32 or more have defined results.

A separate immediate path builds the operand from an 8-bit constant. The constant is zero-extended and rotated right by twice a 4-bit field, so only even rotations can be reached. When immediate mode is selected, this result replaces the shifter result entirely. Operation codes on `op_i`: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. `amt_src_i` = 0 selects the instruction field, and 1 selects the register byte.

Top module: `bshift_top`

## Requirements
- R1: An amount of zero passes `value_i` unchanged, with `carry_o` equal to `carry_i`. This holds for a register amount of zero with any operation code, and for an instruction-field amount of zero with logical left (code 0).
- R2: Logical left by n (1..31) shifts zeros in at the bottom, and `carry_o` is bit 32-n of the input (the last bit shifted out).
- R3: Logical right by n (1..31) shifts zeros in at the top, and `carry_o` is input bit n-1. An instruction-field amount of zero with code 1 means a shift by 32: the result is zero and `carry_o` is input bit 31.
- R4: Arithmetic right by n copies input bit 31 into the vacated upper bits, and `carry_o` is input bit n-1. An instruction-field amount of zero with code 2 means a shift by 32.
- R5: Rotate right by a field amount n (1..31) moves the low n bits to the top, and `carry_o` equals result bit 31. A field amount of zero with code 3 selects rotate right extended.
- R6: Rotate right extended gives `{carry_i, value_i[31:1]}`, and `carry_o` is input bit 0.
- R7: A register amount uses only `amt_reg_i[7:0]`. With logical left or logical right and an amount of exactly 32, the result is zero and `carry_o` is input bit 0 (left) or bit 31 (right). An amount above 32 gives zero with `carry_o` = 0.
- R8: A register arithmetic right by 32 or more fills all result bits and `carry_o` with input bit 31.
- R9: A register rotate right uses the amount modulo 32. A nonzero multiple of 32 returns the input unchanged, with `carry_o` equal to input bit 31.
- R10: In immediate mode, the result is `{24'b0, imm_i}` rotated right by 2*`imm_rot_i`. `carry_o` equals `carry_i` when `imm_rot_i` is 0, and result bit 31 otherwise.
- R11: In immediate mode, `value_i`, `op_i`, `amt_src_i`, `amt_field_i` and `amt_reg_i` have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| value_i | input | 32 | Source value to shift |
| op_i | input | 2 | Operation code (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| amt_src_i | input | 1 | Amount source: 0 instruction field, 1 register byte |
| amt_field_i | input | 5 | Instruction-field shift amount |
| amt_reg_i | input | 32 | Register holding the amount in its low byte |
| carry_i | input | 1 | Incoming carry flag |
| imm_sel_i | input | 1 | Select the rotated immediate operand |
| imm_i | input | 8 | Immediate constant |
| imm_rot_i | input | 4 | Immediate rotate field (rotation = 2x) |
| operand_o | output | 32 | Prepared operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Asymmetric values such as 0xA5A53C0F and 0x80000001 are used so that every direction and fill can be told apart. An LSL cannot be mistaken for a rotate, and a sign fill cannot be mistaken for a zero fill. Every field amount 0..31 is swept for each operation code to separate the zero-field special encodings from ordinary shifts. Register amounts 0..40 plus 128 and 255 are swept, with garbage in the upper register bits, to expose the 32, above-32 and modulo-32 boundaries and the low-byte selection. The immediate path is run over all sixteen rotate values, with the shift inputs varied, to separate its carry rule and its independence from the shifter.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    OP_LSL = 2'd0,
    OP_LSR = 2'd1,
    OP_ASR = 2'd2,
    OP_ROR = 2'd3
  } shift_op_e;

  typedef enum logic [2:0] {
    K_PASS = 3'd0,
    K_LSL  = 3'd1,
    K_LSR  = 3'd2,
    K_ASR  = 3'd3,
    K_ROR  = 3'd4,
    K_RRX  = 3'd5
  } shift_kind_e;
endpackage

// File: rtl/bshift_amt_decode.sv
module bshift_amt_decode
  import bshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8,
  localparam int FLD_W    = $clog2(DATA_W)
) (
  input  logic [1:0]           op_i,
  input  logic                 amt_src_i,
  input  logic [FLD_W-1:0]     amt_field_i,
  input  logic [DATA_W-1:0]    amt_reg_i,
  output shift_kind_e          kind_o,
  output logic [REG_AMT_W-1:0] amt_o
);
  shift_op_e            op;
  logic [REG_AMT_W-1:0] raw_amt;
  logic                 unused_hi;

  assign op        = shift_op_e'(op_i);
  assign unused_hi = ^amt_reg_i[DATA_W-1:REG_AMT_W];
  assign raw_amt   = amt_src_i ? amt_reg_i[REG_AMT_W-1:0]
                               : REG_AMT_W'(amt_field_i);

  always_comb begin
    amt_o  = raw_amt;
    kind_o = K_PASS;
    if (raw_amt == '0) begin
      // zero field re-encodes wide shifts and rrx
      if (!amt_src_i) begin
        unique case (op)
          OP_LSR: begin kind_o = K_LSR; amt_o = REG_AMT_W'(DATA_W); end
          OP_ASR: begin kind_o = K_ASR; amt_o = REG_AMT_W'(DATA_W); end
          OP_ROR: kind_o = K_RRX;
          default: kind_o = K_PASS;
        endcase
      end
    end else begin
      unique case (op)
        OP_LSL:  kind_o = K_LSL;
        OP_LSR:  kind_o = K_LSR;
        OP_ASR:  kind_o = K_ASR;
        default: kind_o = K_ROR;
      endcase
    end
  end

  always_comb begin
    // R1
    if (amt_src_i && amt_reg_i[REG_AMT_W-1:0] == '0)
      reg_zero_pass_chk: assert (kind_o == K_PASS)
        else $error("register amount zero not passed");
    // R5
    if (!amt_src_i && amt_field_i == '0 && op == OP_ROR)
      field_rrx_chk: assert (kind_o == K_RRX)
        else $error("zero field rotate not rrx");
  end
endmodule

// File: rtl/bshift_core.sv
module bshift_core
  import bshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8,
  localparam int FLD_W    = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]    value_i,
  input  shift_kind_e          kind_i,
  input  logic [REG_AMT_W-1:0] amt_i,
  input  logic                 carry_i,
  output logic [DATA_W-1:0]    res_o,
  output logic                 carry_o
);
  logic [DATA_W:0]          lsl_t;
  logic [DATA_W:0]          lsr_t;
  logic signed [DATA_W:0]   asr_src;
  logic [DATA_W:0]          asr_t;
  logic [2*DATA_W-1:0]      ror_t;
  logic [FLD_W-1:0]         ror_amt;

  // extra bit on the far side catches the last bit shifted out
  assign lsl_t   = {1'b0, value_i} << amt_i;
  assign lsr_t   = {value_i, 1'b0} >> amt_i;
  assign asr_src = {value_i, 1'b0};
  assign asr_t   = asr_src >>> amt_i;
  assign ror_amt = amt_i[FLD_W-1:0];
  assign ror_t   = {value_i, value_i} >> ror_amt;

  always_comb begin
    res_o   = value_i;
    carry_o = carry_i;
    unique case (kind_i)
      K_LSL: begin res_o = lsl_t[DATA_W-1:0]; carry_o = lsl_t[DATA_W]; end
      K_LSR: begin res_o = lsr_t[DATA_W:1];   carry_o = lsr_t[0];      end
      K_ASR: begin res_o = asr_t[DATA_W:1];   carry_o = asr_t[0];      end
      K_ROR: begin
        res_o   = ror_t[DATA_W-1:0];
        carry_o = ror_t[DATA_W-1];
      end
      K_RRX: begin res_o = {carry_i, value_i[DATA_W-1:1]}; carry_o = value_i[0]; end
      default: ;
    endcase
  end

  always_comb begin
    // R1
    if (kind_i == K_PASS)
      pass_chk: assert (res_o == value_i && carry_o == carry_i)
        else $error("pass altered operand");
    // R6
    if (kind_i == K_RRX)
      rrx_chk: assert (res_o[DATA_W-1] == carry_i && carry_o == value_i[0])
        else $error("rrx carry path wrong");
    // R7
    if ((kind_i == K_LSL || kind_i == K_LSR) && amt_i > REG_AMT_W'(DATA_W))
      over_shift_chk: assert (res_o == '0 && !carry_o)
        else $error("overlong logical shift not zero");
    // R8
    if (kind_i == K_ASR && amt_i >= REG_AMT_W'(DATA_W))
      asr_fill_chk: assert (res_o == {DATA_W{value_i[DATA_W-1]}} &&
                            carry_o == value_i[DATA_W-1])
        else $error("asr fill wrong");
    // R9
    if (kind_i == K_ROR)
      ror_pop_chk: assert ($countones(res_o) == $countones(value_i) &&
                           carry_o == res_o[DATA_W-1])
        else $error("rotate lost bits");
  end
endmodule

// File: rtl/bshift_imm_rot.sv
module bshift_imm_rot #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int SH_W = ROT_W + 1;

  logic [DATA_W-1:0]   imm_ext;
  logic [SH_W-1:0]     rot_amt;
  logic [2*DATA_W-1:0] dbl;

  assign imm_ext = DATA_W'(imm_i);
  assign rot_amt = {rot_i, 1'b0};
  assign dbl     = {imm_ext, imm_ext} >> rot_amt;
  assign res_o   = dbl[DATA_W-1:0];
  assign carry_o = (rot_i == '0) ? carry_i : res_o[DATA_W-1];

  always_comb begin
    // R10
    if (rot_i == '0)
      imm_norot_chk: assert (res_o == imm_ext && carry_o == carry_i)
        else $error("unrotated immediate wrong");
    // R10
    imm_pop_chk: assert ($countones(res_o) == $countones(imm_i))
      else $error("immediate rotation lost bits");
  end
endmodule

// File: rtl/bshift_top.sv
module bshift_top
  import bshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8,
  parameter int IMM_W     = 8,
  parameter int ROT_W     = 4,
  localparam int FLD_W    = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic [1:0]        op_i,
  input  logic              amt_src_i,
  input  logic [FLD_W-1:0]  amt_field_i,
  input  logic [DATA_W-1:0] amt_reg_i,
  input  logic              carry_i,
  input  logic              imm_sel_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ROT_W-1:0]  imm_rot_i,
  output logic [DATA_W-1:0] operand_o,
  output logic              carry_o
);
  shift_kind_e          kind;
  logic [REG_AMT_W-1:0] amt;
  logic [DATA_W-1:0]    sh_res;
  logic                 sh_carry;
  logic [DATA_W-1:0]    imm_res;
  logic                 imm_carry;

  bshift_amt_decode #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) i_decode (
    .op_i       (op_i),
    .amt_src_i  (amt_src_i),
    .amt_field_i(amt_field_i),
    .amt_reg_i  (amt_reg_i),
    .kind_o     (kind),
    .amt_o      (amt)
  );

  bshift_core #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) i_core (
    .value_i(value_i),
    .kind_i (kind),
    .amt_i  (amt),
    .carry_i(carry_i),
    .res_o  (sh_res),
    .carry_o(sh_carry)
  );

  bshift_imm_rot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) i_imm (
    .imm_i  (imm_i),
    .rot_i  (imm_rot_i),
    .carry_i(carry_i),
    .res_o  (imm_res),
    .carry_o(imm_carry)
  );

  assign operand_o = imm_sel_i ? imm_res   : sh_res;
  assign carry_o   = imm_sel_i ? imm_carry : sh_carry;

  always_comb begin
    // R11
    if (imm_sel_i && imm_rot_i == '0)
      imm_upper_chk: assert (operand_o[DATA_W-1:IMM_W] == '0 && carry_o == carry_i)
        else $error("shifter leaked into immediate");
  end
endmodule

// File: tb/test_bshift_top.sv
module test_bshift_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] value;
  logic [1:0]  op;
  logic        src;
  logic [4:0]  fld;
  logic [31:0] areg;
  logic        cin;
  logic        isel;
  logic [7:0]  imm;
  logic [3:0]  rot;
  logic [31:0] res;
  logic        cout;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  bshift_top i_bshift_top (
    .value_i(value), .op_i(op), .amt_src_i(src), .amt_field_i(fld),
    .amt_reg_i(areg), .carry_i(cin), .imm_sel_i(isel), .imm_i(imm),
    .imm_rot_i(rot), .operand_o(res), .carry_o(cout)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        src;
    logic [4:0]  fld;
    logic [31:0] areg;
    logic        cin;
    logic        isel;
    logic [7:0]  imm;
    logic [3:0]  rot;
    logic [31:0] val;
    logic [31:0] exp;
    logic        expc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{2'd0,1'b0,5'd0, 32'h0,  1'b1,1'b0,8'h00,4'd0,32'h8000_0001,32'h8000_0001,1'b1,4'd1},  // R1
    '{2'd0,1'b0,5'd1, 32'h0,  1'b0,1'b0,8'h00,4'd0,32'h8000_0001,32'h0000_0002,1'b1,4'd2},  // R2
    '{2'd0,1'b0,5'd4, 32'h0,  1'b0,1'b0,8'h00,4'd0,32'hF000_0000,32'h0000_0000,1'b1,4'd2},  // R2
    '{2'd1,1'b0,5'd1, 32'h0,  1'b0,1'b0,8'h00,4'd0,32'h8000_0001,32'h4000_0000,1'b1,4'd3},  // R3
    '{2'd1,1'b0,5'd0, 32'h0,  1'b0,1'b0,8'h00,4'd0,32'h8000_0001,32'h0000_0000,1'b1,4'd3},  // R3
    '{2'd2,1'b0,5'd4, 32'h0,  1'b1,1'b0,8'h00,4'd0,32'h8000_0010,32'hF800_0001,1'b0,4'd4},  // R4
    '{2'd2,1'b0,5'd0, 32'h0,  1'b0,1'b0,8'h00,4'd0,32'h8000_0000,32'hFFFF_FFFF,1'b1,4'd4},  // R4
    '{2'd3,1'b0,5'd4, 32'h0,  1'b0,1'b0,8'h00,4'd0,32'h0000_001F,32'hF000_0001,1'b1,4'd5},  // R5
    '{2'd3,1'b0,5'd0, 32'h0,  1'b1,1'b0,8'h00,4'd0,32'h0000_0003,32'h8000_0001,1'b1,4'd6},  // R6
    '{2'd0,1'b1,5'd7, 32'h120,1'b0,1'b0,8'h00,4'd0,32'h0000_0001,32'h0000_0000,1'b1,4'd7},  // R7
    '{2'd1,1'b1,5'd0, 32'h21, 1'b1,1'b0,8'h00,4'd0,32'hFFFF_FFFF,32'h0000_0000,1'b0,4'd7},  // R7
    '{2'd1,1'b1,5'd0, 32'h20, 1'b0,1'b0,8'h00,4'd0,32'h8000_0000,32'h0000_0000,1'b1,4'd7},  // R7
    '{2'd2,1'b1,5'd0, 32'hC8, 1'b0,1'b0,8'h00,4'd0,32'h8000_0000,32'hFFFF_FFFF,1'b1,4'd8},  // R8
    '{2'd2,1'b1,5'd0, 32'h28, 1'b1,1'b0,8'h00,4'd0,32'h7FFF_FFFF,32'h0000_0000,1'b0,4'd8},  // R8
    '{2'd3,1'b1,5'd0, 32'h40, 1'b0,1'b0,8'h00,4'd0,32'h8000_0000,32'h8000_0000,1'b1,4'd9},  // R9
    '{2'd3,1'b1,5'd0, 32'h24, 1'b1,1'b0,8'h00,4'd0,32'h0000_0010,32'h0000_0001,1'b0,4'd9},  // R9
    '{2'd2,1'b1,5'd9, 32'hF00,1'b1,1'b0,8'h00,4'd0,32'h1234_5678,32'h1234_5678,1'b1,4'd1},  // R1
    '{2'd0,1'b0,5'd0, 32'h0,  1'b1,1'b1,8'hFF,4'd0,32'h0000_0000,32'h0000_00FF,1'b1,4'd10}, // R10
    '{2'd0,1'b0,5'd0, 32'h0,  1'b0,1'b1,8'hFF,4'd4,32'h0000_0000,32'hFF00_0000,1'b1,4'd10}, // R10
    '{2'd0,1'b0,5'd0, 32'h0,  1'b1,1'b1,8'h01,4'd1,32'h0000_0000,32'h4000_0000,1'b0,4'd10}, // R10
    '{2'd0,1'b0,5'd5, 32'h3,  1'b0,1'b1,8'h03,4'd15,32'hFFFF_FFFF,32'h0000_000C,1'b0,4'd11} // R11
  };

  function automatic logic [32:0] model(input logic [1:0] m_op, input logic m_src,
                                        input logic [4:0] m_fld, input logic [31:0] m_reg,
                                        input logic m_cin, input logic m_isel,
                                        input logic [7:0] m_imm, input logic [3:0] m_rot,
                                        input logic [31:0] m_val);
    logic [31:0] r;
    logic        c;
    int          n;
    if (m_isel) begin
      r = {24'b0, m_imm};
      for (int i = 0; i < 2 * int'(m_rot); i++) r = {r[0], r[31:1]};
      c = (m_rot == 0) ? m_cin : r[31];
      return {c, r};
    end
    n = m_src ? int'(m_reg[7:0]) : int'(m_fld);
    if (n == 0) begin
      if (m_src || m_op == 2'd0) return {m_cin, m_val};
      if (m_op == 2'd3) return {m_val[0], m_cin, m_val[31:1]};
      n = 32;
    end
    r = m_val;
    c = m_cin;
    for (int i = 0; i < n; i++) begin
      case (m_op)
        2'd0:    begin c = r[31]; r = {r[30:0], 1'b0}; end
        2'd1:    begin c = r[0];  r = {1'b0, r[31:1]}; end
        2'd2:    begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0];  r = {r[0], r[31:1]}; end
      endcase
    end
    return {c, r};
  endfunction

  task automatic check(input string tag, input logic [31:0] exp, input logic expc);
    total++;
    if (res !== exp || cout !== expc) begin
      bad++;
      $display("FAIL %s: op=%0d src=%0b fld=%0d reg=%h val=%h isel=%0b imm=%h rot=%0d got %h/%0b exp %h/%0b",
               tag, op, src, fld, areg, value, isel, imm, rot, res, cout, exp, expc);
    end
  endtask

  task automatic drive(input logic [1:0] d_op, input logic d_src, input logic [4:0] d_fld,
                       input logic [31:0] d_reg, input logic d_cin, input logic d_isel,
                       input logic [7:0] d_imm, input logic [3:0] d_rot,
                       input logic [31:0] d_val);
    @(negedge clk);
    op = d_op; src = d_src; fld = d_fld; areg = d_reg; cin = d_cin;
    isel = d_isel; imm = d_imm; rot = d_rot; value = d_val;
    #2;
  endtask

  task automatic run_model(input string tag, input logic [1:0] d_op, input logic d_src,
                           input logic [4:0] d_fld, input logic [31:0] d_reg,
                           input logic d_cin, input logic d_isel, input logic [7:0] d_imm,
                           input logic [3:0] d_rot, input logic [31:0] d_val);
    logic [32:0] e;
    drive(d_op, d_src, d_fld, d_reg, d_cin, d_isel, d_imm, d_rot, d_val);
    e = model(d_op, d_src, d_fld, d_reg, d_cin, d_isel, d_imm, d_rot, d_val);
    check(tag, e[31:0], e[32]);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
    end
  end

  localparam logic [31:0] PAT [3] = '{32'hA5A5_3C0F, 32'h8000_0001, 32'h7FFF_FFFE};

  initial begin
    op = '0; src = 1'b0; fld = '0; areg = '0; cin = 1'b0;
    isel = 1'b0; imm = '0; rot = '0; value = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle inputs after reset: zero amount passes zero value (R1)
    drive(2'd0, 1'b0, 5'd0, 32'h0, 1'b0, 1'b0, 8'h0, 4'd0, 32'h0);
    check("R1 idle", 32'h0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      drive(TBL[k].op, TBL[k].src, TBL[k].fld, TBL[k].areg, TBL[k].cin,
            TBL[k].isel, TBL[k].imm, TBL[k].rot, TBL[k].val);
      check($sformatf("R%0d vec%0d", TBL[k].req, k), TBL[k].exp, TBL[k].expc);
    end

    // field amounts, all codes: R2 R3 R4 R5 R6
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 3; p++)
          for (int c = 0; c < 2; c++)
            run_model("R2-field sweep", 2'(o), 1'b0, 5'(a), 32'hDEAD_BE00,
                      1'(c), 1'b0, 8'h0, 4'd0, PAT[p]);

    // register amounts with garbage upper bits: R7 R8 R9
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < 43; a++)
        for (int p = 0; p < 3; p++) begin
          logic [7:0] amt;
          amt = (a == 41) ? 8'd128 : (a == 42) ? 8'd255 : 8'(a);
          run_model("R7 R8 R9 reg sweep", 2'(o), 1'b1, 5'(a), {24'h5A5A5A, amt},
                    1'(a & 1), 1'b0, 8'h0, 4'd0, PAT[p]);
        end

    // immediate path with shift inputs varied: R10 R11
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 2; c++) begin
        run_model("R10 imm sweep", 2'(r), 1'(r & 1), 5'(r), 32'h1F,
                  1'(c), 1'b1, 8'hB3, 4'(r), PAT[r % 3]);
        run_model("R11 imm ignore", 2'(3 - (r % 4)), 1'b1, 5'd0, 32'h40,
                  1'(c), 1'b1, 8'hB3, 4'(r), 32'hFFFF_0000);
      end

    finish_run();
  end
endmodule